// File: doc/BRIEF.md
# SIMT Lane Predication Mask Controller

This block tracks which lanes of a 64-lane wavefront are enabled as the instruction stream enters and leaves if/else regions. All lanes receive every instruction in lockstep. The active mask output gates register writes and operand reads in the datapath, so lanes whose predicate is false neither read operands nor write results.

At an IF command, each lane's condition bit is combined with the current mask. At an ELSE command, the lanes that were enabled before the branch but failed the condition take over. At an ENDIF command, the mask that held before the region returns. Nested regions are kept on a stack of saved masks.

When a divergent branch splits the wavefront, both sides are issued, each under its own mask. When every lane takes the same side, the other side has an all-zero mask. A skip flag then tells the issue logic that it may jump over that side. Stack misuse raises a sticky error and leaves the mask as it was.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset the active mask is all ones, the error flag is 0 and skip is 0.
- R2: An accepted IF (cmd_valid=1, cmd_op=2'b00) sets the mask, from the next clock edge, to the previous mask AND cond.
- R3: An ELSE (cmd_op=2'b01) sets the mask to the mask held before the matching IF AND NOT that IF's cond.
- R4: An ENDIF (cmd_op=2'b10) restores the mask held before the matching IF and pops one nesting level.
- R5: Regions nest up to DEPTH levels (default 8), and each ELSE and ENDIF refers to its own enclosing IF.
- R6: skip is 1 exactly when the active mask has no lane set. This flags the empty side of a uniform branch.
- R7: An IF arriving when DEPTH levels are already open sets the error flag and leaves the mask and the stack unchanged.
- R8: An ELSE or ENDIF arriving with no open region sets the error flag and leaves the mask unchanged.
- R9: The error flag stays set until reset.
- R10: With cmd_valid=0, or with cmd_op=2'b11, the mask does not change and cond is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 00 IF, 01 ELSE, 10 ENDIF, 11 no operation |
| cond | input | LANES | Per-lane branch condition, used by IF |
| active_mask | output | LANES | Lanes allowed to read operands and write results |
| skip | output | 1 | Current path has no active lane |
| err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Some properties are checked by assertions on every cycle:
- An IF never enables a lane that was off before it.
- Idle cycles and misuse never move the mask.
- The error flag never clears on its own.
- The nesting depth never exceeds its bound.

Other behaviour needs a known prior history, so only the directed scenarios can show it:
- The exact complement at ELSE.
- The restore at ENDIF.
- Correct pairing across nested levels.
- The skip flag on uniform branches.

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl #(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] active_mask,
  output logic             skip,
  output logic             err
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] OP_IF = 2'b00;
  localparam logic [1:0] OP_ELSE = 2'b01;
  localparam logic [1:0] OP_END = 2'b10;

  logic [LANES-1:0] outer_q [DEPTH];
  logic [LANES-1:0] taken_q [DEPTH];
  logic [PW-1:0]    depth_q;
  logic [AW-1:0]    top_idx, push_idx;

  wire full    = (depth_q == PW'(DEPTH));
  wire empty   = (depth_q == '0);
  wire do_if   = cmd_valid && (cmd_op == OP_IF);
  wire do_else = cmd_valid && (cmd_op == OP_ELSE);
  wire do_end  = cmd_valid && (cmd_op == OP_END);
  wire bad     = (do_if && full) || ((do_else || do_end) && empty);

  assign top_idx  = AW'(depth_q - PW'(1));
  assign push_idx = AW'(depth_q);
  assign skip     = ~|active_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '1;
      depth_q     <= '0;
      err         <= 1'b0;
    end else if (bad) begin
      err <= 1'b1;
    end else if (do_if) begin
      active_mask <= active_mask & cond;
      depth_q     <= depth_q + PW'(1);
    end else if (do_else) begin
      active_mask <= outer_q[top_idx] & ~taken_q[top_idx];
    end else if (do_end) begin
      active_mask <= outer_q[top_idx];
      depth_q     <= depth_q - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_if && !full) begin
      outer_q[push_idx] <= active_mask;
      taken_q[push_idx] <= active_mask & cond;
    end
  end

  // R2
  if_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_if && !full |=> (active_mask & ~$past(active_mask)) == '0);
  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_if && full |=> $stable(active_mask) && err);
  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_else || do_end) && empty |=> $stable(active_mask) && err);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(active_mask));
  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= PW'(DEPTH));
endmodule

// File: tb/simt_mask_ctrl_test.sv
module simt_mask_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 2'b11;
  logic [63:0] cond = '0;
  logic [63:0] active_mask;
  logic        skip, err;
  int checks = 0, fails = 0;
  localparam logic [63:0] ONES = '1;

  always #2 clk = ~clk;

  simt_mask_ctrl uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cond(cond), .active_mask(active_mask), .skip(skip), .err(err));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic [63:0] c);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cond = c;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 2'b11; cond = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mask", active_mask, ONES);
    chk("R1 err", {63'b0, err}, 64'd0);
    chk("R1 skip", {63'b0, skip}, 64'd0);
  endtask

  task automatic t_divergent();
    issue(1, 2'b00, 64'h5555_5555_5555_5555);
    chk("R2 if mask", active_mask, 64'h5555_5555_5555_5555);
    chk("R6 skip low", {63'b0, skip}, 64'd0);
    issue(1, 2'b01, '0);
    chk("R3 else mask", active_mask, 64'hAAAA_AAAA_AAAA_AAAA);
    issue(1, 2'b10, '0);
    chk("R4 endif mask", active_mask, ONES);
  endtask

  task automatic t_uniform();
    issue(1, 2'b00, ONES);
    chk("R6 if all", {63'b0, skip}, 64'd0);
    issue(1, 2'b01, '0);
    chk("R6 else empty mask", active_mask, 64'd0);
    chk("R6 else skip", {63'b0, skip}, 64'd1);
    issue(1, 2'b10, '0);
    chk("R6 endif skip", {63'b0, skip}, 64'd0);
    issue(1, 2'b00, '0);
    chk("R6 if none skip", {63'b0, skip}, 64'd1);
    issue(1, 2'b01, '0);
    chk("R3 else all", active_mask, ONES);
    issue(1, 2'b10, '0);
  endtask

  task automatic t_nested();
    issue(1, 2'b00, 64'h0000_0000_FFFF_FFFF);
    issue(1, 2'b00, 64'h0F0F_0F0F_0F0F_0F0F);
    chk("R5 inner if", active_mask, 64'h0000_0000_0F0F_0F0F);
    issue(1, 2'b01, '0);
    chk("R5 inner else", active_mask, 64'h0000_0000_F0F0_F0F0);
    issue(1, 2'b10, '0);
    chk("R5 inner endif", active_mask, 64'h0000_0000_FFFF_FFFF);
    issue(1, 2'b01, '0);
    chk("R5 outer else", active_mask, 64'hFFFF_FFFF_0000_0000);
    issue(1, 2'b10, '0);
    chk("R5 outer endif", active_mask, ONES);
  endtask

  task automatic t_idle();
    issue(0, 2'b00, '0);
    chk("R10 invalid ignored", active_mask, ONES);
    issue(1, 2'b11, '0);
    chk("R10 nop ignored", active_mask, ONES);
    issue(1, 2'b10, '0);
    chk("R10 stack still empty", {63'b0, err}, 64'd1);
  endtask

  task automatic t_underflow();
    do_reset();
    issue(1, 2'b01, '0);
    chk("R8 else err", {63'b0, err}, 64'd1);
    chk("R8 mask held", active_mask, ONES);
    do_reset();
    issue(1, 2'b10, '0);
    chk("R8 endif err", {63'b0, err}, 64'd1);
    chk("R8 mask held", active_mask, ONES);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) issue(1, 2'b00, ~(64'd1 << i));
    chk("R7 full mask", active_mask, 64'hFFFF_FFFF_FFFF_FF00);
    chk("R7 no err yet", {63'b0, err}, 64'd0);
    issue(1, 2'b00, '0);
    chk("R7 err", {63'b0, err}, 64'd1);
    chk("R7 mask held", active_mask, 64'hFFFF_FFFF_FFFF_FF00);
    issue(1, 2'b10, '0);
    chk("R7 stack intact", active_mask, 64'hFFFF_FFFF_FFFF_FF80);
    for (int i = 0; i < 7; i++) issue(1, 2'b10, '0);
    chk("R5 deep restore", active_mask, ONES);
    chk("R9 err sticky", {63'b0, err}, 64'd1);
  endtask

  initial begin
    t_reset();
    t_divergent();
    t_uniform();
    t_nested();
    t_idle();
    t_underflow();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule